// File: doc/BRIEF.md
# Synchronous Tri-Port Bus Exchanger

This block passes data between one host-side port and two memory-side ports, so that a single host bus can serve an even bank and an odd bank in turn. Every path runs through a register, and all registers share one rising-edge clock. Two registers carry host data outward, one per memory-side port. Either or both of them may capture the host word on the same edge. Two more registers capture the memory-side words heading back to the host. A registered selection decides which of those two reaches the host port.

Each data register has its own active-low load enable. When that enable is high at an edge, the register keeps its value. The source selection and the two active-low drive controls are captured together in a control register. One drive control belongs to the host port, and the other is shared by both memory-side ports. Changes to selection and drive direction therefore take effect only on a clock edge. Each bidirectional port appears as an input word, an output word and an output-enable bit. An output-enable of 0 stands for a floating pin.

Top module: `bus_exchanger`

## Requirements
- R1: While `rst` is high at a rising edge, every data register clears to zero and the control register selects the 2B path with both drive controls released. From the next cycle, all output words are 0 and `aOe`, `b1Oe` and `b2Oe` are 0.
- R2: The register behind `b1Out` captures `aIn` at a rising edge when `loadToB1N` is 0, and otherwise keeps its value. `b1Out` shows that register in the following cycle.
- R3: The register behind `b2Out` captures `aIn` at a rising edge when `loadToB2N` is 0, and otherwise keeps its value. It is independent of R2, so both registers may load the same word on one edge.
- R4: The two return registers capture `b1In` when `loadFromB1N` is 0 and `b2In` when `loadFromB2N` is 0, each independently, and otherwise keep their values.
- R5: `pickB1` is sampled at the rising edge. After an edge where it was 1, `aOut` shows the 1B return register. After an edge where it was 0, `aOut` shows the 2B return register. `aOut` follows a load of the selected register in the cycle after that load.
- R6: After each rising edge, `aOe` equals the inverse of the value `aDriveN` had at that edge, and `aOe` does not change between edges.
- R7: After each rising edge, `b1Oe` and `b2Oe` both equal the inverse of the value `bDriveN` had at that edge, so the two are always equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| loadToB1N | input | 1 | Active-low load of the host-to-1B register |
| loadToB2N | input | 1 | Active-low load of the host-to-2B register |
| loadFromB1N | input | 1 | Active-low load of the 1B-to-host register |
| loadFromB2N | input | 1 | Active-low load of the 2B-to-host register |
| pickB1 | input | 1 | Path select sampled at the edge: 1 picks 1B, 0 picks 2B |
| aDriveN | input | 1 | Active-low drive control for the host port, registered |
| bDriveN | input | 1 | Active-low drive control shared by both memory ports, registered |
| aIn | input | WIDTH | Host port input word |
| aOut | output | WIDTH | Host port output word |
| aOe | output | 1 | Host port output enable |
| b1In | input | WIDTH | 1B port input word |
| b1Out | output | WIDTH | 1B port output word |
| b1Oe | output | 1 | 1B port output enable |
| b2In | input | WIDTH | 2B port input word |
| b2Out | output | WIDTH | 2B port output word |
| b2Oe | output | 1 | 2B port output enable |

## Verification
The hardest case to reach from the ports is an edge where the selection flips while the newly selected return register is loading at the same time. In that case `aOut` must show the new word at once, not the held value of either register. The stimulus toggles `pickB1` on every cycle and loads both return registers with different words on the same edges. It also toggles both drive controls during a load, so that an off-by-one cycle in enable timing shows up as a mismatch. A long stretch of random control and data patterns follows, and a reset is applied in the middle of traffic.

// File: rtl/xchg_pkg.sv
package xchg_pkg;
  localparam int NUM_REGS = 4;
  // register slots; the order fixes which source feeds each slot
  localparam int SLOT_TO_B1   = 0;
  localparam int SLOT_TO_B2   = 1;
  localparam int SLOT_FROM_B1 = 2;
  localparam int SLOT_FROM_B2 = 3;

  typedef struct packed {
    logic [NUM_REGS-1:0] load;   // active-high load strobe per slot
    logic                pickB1; // registered return-path select
    logic                driveA; // registered host-port drive
    logic                driveB; // registered memory-port drive
  } xchgStrobes_t;
endpackage

// File: rtl/xchg_control.sv
module xchg_control
  import xchg_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         loadToB1N,
  input  logic         loadToB2N,
  input  logic         loadFromB1N,
  input  logic         loadFromB2N,
  input  logic         pickB1,
  input  logic         aDriveN,
  input  logic         bDriveN,
  output xchgStrobes_t strb
);
  logic pickQ, driveAQ, driveBQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      pickQ   <= 1'b0;
      driveAQ <= 1'b0;
      driveBQ <= 1'b0;
    end else begin
      pickQ   <= pickB1;
      driveAQ <= ~aDriveN;
      driveBQ <= ~bDriveN;
    end
  end

  always_comb begin
    strb                    = '0;
    strb.load[SLOT_TO_B1]   = ~loadToB1N;
    strb.load[SLOT_TO_B2]   = ~loadToB2N;
    strb.load[SLOT_FROM_B1] = ~loadFromB1N;
    strb.load[SLOT_FROM_B2] = ~loadFromB2N;
    strb.pickB1             = pickQ;
    strb.driveA             = driveAQ;
    strb.driveB             = driveBQ;
  end
endmodule

// File: rtl/xchg_datapath.sv
module xchg_datapath
  import xchg_pkg::*;
#(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  xchgStrobes_t     strb,
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] b1In,
  input  logic [WIDTH-1:0] b2In,
  output logic [WIDTH-1:0] aOut,
  output logic [WIDTH-1:0] b1Out,
  output logic [WIDTH-1:0] b2Out
);
  logic [WIDTH-1:0] srcVec [NUM_REGS];
  logic [WIDTH-1:0] regQ   [NUM_REGS];

  assign srcVec[SLOT_TO_B1]   = aIn;
  assign srcVec[SLOT_TO_B2]   = aIn;
  assign srcVec[SLOT_FROM_B1] = b1In;
  assign srcVec[SLOT_FROM_B2] = b2In;

  for (genvar g = 0; g < NUM_REGS; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (rst)              regQ[g] <= '0;
      else if (strb.load[g]) regQ[g] <= srcVec[g];
    end

    // R2, R3, R4: a strobed slot takes its source word
    assert_load_R2: assert property (@(posedge clk) disable iff (rst)
      (strb.load[g]) |=> (regQ[g] == $past(srcVec[g])));
    // R2, R3, R4: an unstrobed slot keeps its word
    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
      (!strb.load[g]) |=> $stable(regQ[g]));
  end

  assign b1Out = regQ[SLOT_TO_B1];
  assign b2Out = regQ[SLOT_TO_B2];
  assign aOut  = strb.pickB1 ? regQ[SLOT_FROM_B1] : regQ[SLOT_FROM_B2];
endmodule

// File: rtl/bus_exchanger.sv
module bus_exchanger
  import xchg_pkg::*;
#(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             loadToB1N,
  input  logic             loadToB2N,
  input  logic             loadFromB1N,
  input  logic             loadFromB2N,
  input  logic             pickB1,
  input  logic             aDriveN,
  input  logic             bDriveN,
  input  logic [WIDTH-1:0] aIn,
  output logic [WIDTH-1:0] aOut,
  output logic             aOe,
  input  logic [WIDTH-1:0] b1In,
  output logic [WIDTH-1:0] b1Out,
  output logic             b1Oe,
  input  logic [WIDTH-1:0] b2In,
  output logic [WIDTH-1:0] b2Out,
  output logic             b2Oe
);
  xchgStrobes_t strb;

  xchg_control uCtrl (
    .clk(clk), .rst(rst),
    .loadToB1N(loadToB1N), .loadToB2N(loadToB2N),
    .loadFromB1N(loadFromB1N), .loadFromB2N(loadFromB2N),
    .pickB1(pickB1), .aDriveN(aDriveN), .bDriveN(bDriveN),
    .strb(strb)
  );

  xchg_datapath #(.WIDTH(WIDTH)) uPath (
    .clk(clk), .rst(rst), .strb(strb),
    .aIn(aIn), .b1In(b1In), .b2In(b2In),
    .aOut(aOut), .b1Out(b1Out), .b2Out(b2Out)
  );

  assign aOe  = strb.driveA;
  assign b1Oe = strb.driveB;
  assign b2Oe = strb.driveB;

  assert_host_enable_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (aOe == !$past(aDriveN)));
  assert_mem_enable_on_R7: assert property (@(posedge clk) disable iff (rst)
    (!bDriveN) |=> (b1Oe && b2Oe));
  assert_mem_enable_off_R7: assert property (@(posedge clk) disable iff (rst)
    (bDriveN) |=> (!b1Oe && !b2Oe));
endmodule

// File: tb/tb_bus_exchanger.sv
module tb_bus_exchanger;
  localparam int W = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic loadToB1N = 1, loadToB2N = 1, loadFromB1N = 1, loadFromB2N = 1;
  logic pickB1 = 0, aDriveN = 1, bDriveN = 1;
  logic [W-1:0] aIn = '0, b1In = '0, b2In = '0;
  logic [W-1:0] aOut, b1Out, b2Out;
  logic aOe, b1Oe, b2Oe;

  always #5 clk = ~clk;

  bus_exchanger #(.WIDTH(W)) dut (.*);

  typedef struct {
    logic [W-1:0] aOut, b1Out, b2Out;
    logic aOe, b1Oe, b2Oe;
    bit afterReset;
  } expItem_t;

  expItem_t scoreQ[$];
  int compared = 0, mismatched = 0;
  bit driverDone = 0;

  // reference state, built from the requirements
  logic [W-1:0] mTo1 = '0, mTo2 = '0, mFr1 = '0, mFr2 = '0;
  logic mPick = 0, mOeA = 0, mOeB = 0;

  task automatic step(input logic r, input logic l1, input logic l2,
                      input logic f1, input logic f2, input logic pk,
                      input logic da, input logic db,
                      input logic [W-1:0] a, input logic [W-1:0] b1,
                      input logic [W-1:0] b2);
    expItem_t it;
    rst = r; loadToB1N = l1; loadToB2N = l2; loadFromB1N = f1; loadFromB2N = f2;
    pickB1 = pk; aDriveN = da; bDriveN = db; aIn = a; b1In = b1; b2In = b2;
    if (r) begin
      mTo1 = '0; mTo2 = '0; mFr1 = '0; mFr2 = '0; mPick = 0; mOeA = 0; mOeB = 0;
    end else begin
      if (!l1) mTo1 = a;
      if (!l2) mTo2 = a;
      if (!f1) mFr1 = b1;
      if (!f2) mFr2 = b2;
      mPick = pk; mOeA = !da; mOeB = !db;
    end
    it.aOut = mPick ? mFr1 : mFr2;
    it.b1Out = mTo1; it.b2Out = mTo2;
    it.aOe = mOeA; it.b1Oe = mOeB; it.b2Oe = mOeB;
    it.afterReset = r;
    scoreQ.push_back(it);
    @(negedge clk);
  endtask

  task automatic cmp(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // monitor: compare after each edge
  always @(posedge clk) begin
    #2;
    if (scoreQ.size() > 0) begin
      expItem_t e;
      e = scoreQ.pop_front();
      if (e.afterReset) begin
        cmp("R1 aOut", aOut, e.aOut);   cmp("R1 b1Out", b1Out, e.b1Out);
        cmp("R1 b2Out", b2Out, e.b2Out); cmp("R1 aOe", W'(aOe), W'(e.aOe));
        cmp("R1 b1Oe", W'(b1Oe), W'(e.b1Oe)); cmp("R1 b2Oe", W'(b2Oe), W'(e.b2Oe));
      end else begin
        cmp("R5/R4 aOut", aOut, e.aOut);
        cmp("R2 b1Out", b1Out, e.b1Out);
        cmp("R3 b2Out", b2Out, e.b2Out);
        cmp("R6 aOe", W'(aOe), W'(e.aOe));
        cmp("R7 b1Oe", W'(b1Oe), W'(e.b1Oe));
        cmp("R7 b2Oe", W'(b2Oe), W'(e.b2Oe));
      end
    end
  end

  initial begin
    @(negedge clk);
    // R1: reset
    step(1,0,0,0,0,1,0,0,12'hFFF,12'hFFF,12'hFFF);
    step(1,1,1,1,1,0,1,1,12'h000,12'h000,12'h000);
    // R3: same word into both outward registers on one edge
    step(0,0,0,1,1,0,1,0,12'hA5C,12'h111,12'h222);
    // R2: only 1B loads, 2B holds
    step(0,0,1,1,1,0,1,0,12'h3C3,12'h111,12'h222);
    step(0,1,1,1,1,0,1,0,12'h777,12'h111,12'h222);
    // memory ports released, return registers load from B side (R4)
    step(0,1,1,0,0,1,0,1,12'h000,12'h123,12'h456);
    // R5: alternate select each cycle while both return registers load
    for (int i = 0; i < 8; i++)
      step(0,1,1,0,0,i[0],0,1,12'h000,12'(12'h100+i),12'(12'h800+i));
    // select held, loads off: aOut holds
    step(0,1,1,1,1,1,0,1,12'h000,12'hBAD,12'hBAD);
    // R6, R7: toggle enables while loading
    for (int i = 0; i < 6; i++)
      step(0,i[1],i[0],i[0],i[1],i[0],i[0],~i[0],12'(12'h0F0+i),12'(12'h050+i),12'(12'h0A0+i));
    // random traffic with a reset in the middle
    for (int i = 0; i < 300; i++)
      step(i == 150, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
           1'($urandom), 1'($urandom), 1'($urandom),
           12'($urandom), 12'($urandom), 12'($urandom));
    step(0,1,1,1,1,0,1,1,12'h000,12'h000,12'h000);
    @(negedge clk);
    driverDone = 1;
  end

  initial begin
    fork
      begin wait (driverDone && scoreQ.size() == 0); end
      begin
        repeat (200000) @(posedge clk);
        mismatched++; compared++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule